// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and Demultiplexer

This block stores eight single-bit values and presents them on an eight-bit parallel output. A three-bit select chooses one output, and a single data line supplies the value for it. Two active-low controls, clear and enable, pick one of four modes:

- **write:** update only the selected bit.
- **hold:** freeze all eight bits.
- **demultiplex:** steer the data line onto the selected output and force every other output low.
- **clear:** force all outputs low.

The block is a synchronous model of level-sensitive behaviour. Every mode takes effect at the rising clock edge, and a synchronous active-high reset starts the block from all-zero.

Moving more than one select bit at once can select the wrong bit for a moment. For that reason the select should only change while the block is in hold mode. A one-bit flag reports any select change that is seen while the block is in write mode, so that misuse is visible.

Top module: `addr_latch8`

## Requirements
- R1: With clr_n=1 and en_n=0 (write mode), after a rising edge q[sel] equals din, and every other bit of q is unchanged.
- R2: With clr_n=1 and en_n=1 (hold mode), q keeps its value across the edge whatever sel and din are.
- R3: With clr_n=0 and en_n=0 (demultiplex mode), after the edge q[sel] equals din and every other bit of q is 0.
- R4: With clr_n=0 and en_n=1 (clear mode), after the edge q is 8'h00 whatever sel and din are.
- R5: sel is an unsigned binary index with bit 0 as the least significant bit: sel=k addresses q[k], for k from 0 to 7.
- R6: addr_misuse is 1 for the cycle after an edge at which the block is in write mode and sel differs from the sel sampled at the previous edge. It is 0 otherwise. Reset sets the previously sampled sel to 0.
- R7: While rst is 1 at a rising edge, q becomes 8'h00 and addr_misuse becomes 0 at that edge.
- R8: The pattern written by demultiplex mode is stored. A following hold keeps it, and a following write changes only the selected bit of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Bit select, binary |
| din | input | 1 | Data line |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear, active low |
| q | output | 8 | Parallel stored outputs |
| addr_misuse | output | 1 | Select changed while in write mode |

## Verification
Writing each select value in turn, first with ones and then with zeros, checks the bit ordering and shows that unselected bits are kept. Hold and clear are each applied with select and data varied, which shows that both inputs are ignored in those modes. Demultiplex is run after a busy stored pattern, which tells "force others low" apart from "keep others". It is then followed by hold and write steps to show that the pattern is stored. A long random run over all mode, select and data combinations is compared against a bench model, with the misuse flag checked on every cycle.

// File: rtl/al8_pkg.sv
package al8_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b01,
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } al8_mode_e;

    // clear and enable are both active low: {clr_n, en_n}
    function automatic al8_mode_e decode_mode(input logic clr_n, input logic en_n);
        unique case ({clr_n, en_n})
            2'b00:   decode_mode = MODE_DEMUX;
            2'b01:   decode_mode = MODE_CLEAR;
            2'b10:   decode_mode = MODE_WRITE;
            default: decode_mode = MODE_HOLD;
        endcase
    endfunction

    typedef struct packed {
        al8_mode_e mode;
        logic      din;
    } al8_ctl_t;
endpackage

// File: rtl/al8_mode_dec.sv
module al8_mode_dec
    import al8_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    input  logic              din,
    input  logic              en_n,
    input  logic              clr_n,
    output al8_ctl_t          ctl,
    output logic [N-1:0]      hit
);
    always_comb begin
        ctl.mode = decode_mode(clr_n, en_n);
        ctl.din  = din;
    end

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_hit
            assign hit[k] = (sel == ADDR_W'(k));
        end
    endgenerate
endmodule

// File: rtl/al8_bit_cell.sv
module al8_bit_cell
    import al8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  al8_ctl_t ctl,
    input  logic     hit,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            unique case (ctl.mode)
                MODE_WRITE: if (hit) q <= ctl.din;
                MODE_DEMUX: q <= hit & ctl.din;
                MODE_CLEAR: q <= 1'b0;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/al8_addr_watch.sv
module al8_addr_watch
    import al8_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  al8_ctl_t          ctl,
    input  logic [ADDR_W-1:0] sel,
    output logic              flag
);
    logic [ADDR_W-1:0] last_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sel <= '0;
            flag     <= 1'b0;
        end else begin
            last_sel <= sel;
            flag     <= (ctl.mode == MODE_WRITE) && (sel != last_sel);
        end
    end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import al8_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sel,
    input  logic              din,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [N-1:0]      q,
    output logic              addr_misuse
);
    al8_ctl_t     ctl;
    logic [N-1:0] hit;

    al8_mode_dec #(.ADDR_W(ADDR_W)) dec_i (
        .sel(sel), .din(din), .en_n(en_n), .clr_n(clr_n),
        .ctl(ctl), .hit(hit)
    );

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_cell
            al8_bit_cell cell_i (
                .clk(clk), .rst(rst), .ctl(ctl), .hit(hit[k]), .q(q[k])
            );
        end
    endgenerate

    al8_addr_watch #(.ADDR_W(ADDR_W)) watch_i (
        .clk(clk), .rst(rst), .ctl(ctl), .sel(sel), .flag(addr_misuse)
    );
endmodule

// File: rtl/al8_chk.sv
module al8_chk #(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sel,
    input logic              din,
    input logic              en_n,
    input logic              clr_n,
    input logic [N-1:0]      q,
    input logic              addr_misuse
);
    p_write_sel_r1: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !en_n) |=> (q[$past(sel)] == $past(din)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_n && en_n) |=> $stable(q));

    p_demux_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !en_n) |=> (q[$past(sel)] == $past(din)) &&
                              ($countones(q) == int'($past(din))));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && en_n) |=> (q == '0));

    p_flag_mode_r6: assert property (@(posedge clk) disable iff (rst)
        addr_misuse |-> $past(clr_n && !en_n));

    p_reset_r7: assert property (@(posedge clk)
        rst |=> (q == '0) && !addr_misuse);
endmodule

bind addr_latch8 al8_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .sel(sel), .din(din), .en_n(en_n),
    .clr_n(clr_n), .q(q), .addr_misuse(addr_misuse)
);

// File: tb/addr_latch8_tb.sv
module addr_latch8_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;
    logic       addr_misuse;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_q = '0;
    logic [2:0] m_last = '0;
    logic       m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_latch8 dut_i (
        .clk(clk), .rst(rst), .sel(sel), .din(din), .en_n(en_n),
        .clr_n(clr_n), .q(q), .addr_misuse(addr_misuse)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with given controls; model updated after the edge
    task automatic step(input logic c, input logic e, input logic d, input logic [2:0] a);
        @(negedge clk);
        clr_n = c; en_n = e; din = d; sel = a;
        @(posedge clk);
        #1;
        case ({c, e})
            2'b10: m_q[a] = d;
            2'b00: begin m_q = '0; m_q[a] = d; end
            2'b01: m_q = '0;
            default: ;
        endcase
        m_flag = (c && !e && (a != m_last));
        m_last = a;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clr_n = 1'b1; en_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        m_q = '0; m_last = '0; m_flag = 1'b0;
        chk("R7 q after reset", q, 8'h00);
        chk("R7 flag after reset", {7'b0, addr_misuse}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_write_walk();
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, 1'b0, 3'(k));
            step(1'b1, 1'b0, 1'b1, 3'(k));
            chk("R5 R1 write one", q, m_q);
        end
        chk("R1 all ones", q, 8'hFF);
        for (int k = 0; k < 8; k += 2) begin
            step(1'b1, 1'b1, 1'b0, 3'(k));
            step(1'b1, 1'b0, 1'b0, 3'(k));
        end
        chk("R1 R5 even cleared", q, 8'hAA);
    endtask

    task automatic t_hold();
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, k[0], 3'(7 - k));
            chk("R2 hold", q, 8'hAA);
        end
    endtask

    task automatic t_demux();
        step(1'b0, 1'b0, 1'b1, 3'd5);
        chk("R3 demux one", q, 8'h20);
        step(1'b0, 1'b0, 1'b0, 3'd2);
        chk("R3 demux zero", q, 8'h00);
        step(1'b0, 1'b0, 1'b1, 3'd3);
        step(1'b1, 1'b1, 1'b0, 3'd6);
        chk("R8 hold keeps demux", q, 8'h08);
        step(1'b1, 1'b1, 1'b0, 3'd0);
        step(1'b1, 1'b0, 1'b1, 3'd0);
        chk("R8 write over demux", q, 8'h09);
    endtask

    task automatic t_clear();
        step(1'b1, 1'b0, 1'b1, 3'd0);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, k[0], 3'(k * 2));
            chk("R4 clear", q, 8'h00);
        end
    endtask

    task automatic t_flag();
        step(1'b1, 1'b1, 1'b0, 3'd4);
        step(1'b1, 1'b0, 1'b1, 3'd4);
        chk("R6 no change no flag", {7'b0, addr_misuse}, 8'h00);
        step(1'b1, 1'b0, 1'b1, 3'd1);
        chk("R6 change in write flags", {7'b0, addr_misuse}, 8'h01);
        step(1'b1, 1'b0, 1'b1, 3'd1);
        chk("R6 flag one cycle", {7'b0, addr_misuse}, 8'h00);
        step(1'b1, 1'b1, 1'b0, 3'd6);
        chk("R6 change in hold no flag", {7'b0, addr_misuse}, 8'h00);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [4:0] r;
            r = 5'($urandom);
            step(r[4], r[3], ^r, r[2:0]);
            chk("R1 R2 R3 R4 random q", q, m_q);
            chk("R6 random flag", {7'b0, addr_misuse}, {7'b0, m_flag});
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_write_walk();
        t_hold();
        t_demux();
        t_clear();
        t_flag();
        t_random();
        // reset in the middle of a pattern
        step(1'b1, 1'b0, 1'b1, 3'd7);
        do_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule